// File: doc/BRIEF.md
# Fixed-Rate Texture Block Decoder

The decoder turns one compressed 64-bit texture block into the colour of a single texel. Each block covers a 4×4 group of texels at a fixed four bits per texel, so a texture unit can find any block by direct address arithmetic. The decoder takes the block word and a 2-bit column and row inside the block, and returns 24-bit RGB one clock later.

A block keeps one base colour for all sixteen texels, a 3-bit selector that chooses a row of a luminance-offset table, and one 2-bit index for each texel. The index picks a signed offset from the chosen row. That offset is added to red, green and blue alike, and each sum saturates to the 8-bit range. The result is lossy by design. The logic is a bit-slice multiplexer, a small constant table, three saturating adders and one output register.

The upstream fetch stage drives one request per cycle at most. The response carries no back-pressure, so the consumer must accept it when it arrives.

Top module: `texblk_decoder`

## Requirements
- R1: While reset is asserted, and until the first request is taken after it, `rsp_valid` is 0 and `rsp_rgb` is 0.
- R2: `rsp_valid` is high in exactly the cycles that follow a cycle with `req_valid` high, so the latency is one clock.
- R3: Field layout: red is bits [63:56], green is [55:48], blue is [47:40], the table selector is [39:37], and the index of texel (x,y) sits at bits [2*(4*y+x)+1 : 2*(4*y+x)].
- R4: Index 0 gives −far, index 1 gives −near, index 2 gives +near and index 3 gives +far. For selector 0 to 7, far is 8,17,29,42,60,80,106,183 and near is 2,5,9,13,18,24,33,47.
- R5: The same offset is applied to all three channels. A grey base therefore gives a grey result.
- R6: Each channel is base plus offset, clamped to 0 below and to 255 above. `rsp_rgb` is {R,G,B} with red in [23:16].
- R7: Bits [36:32] of the block have no effect on the result.
- R8: In a cycle after one with `req_valid` low, `rsp_rgb` keeps its previous value.
- R9: Requests on consecutive cycles each produce their own correct response on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_block | input | 64 | Compressed block word |
| req_x | input | 2 | Texel column inside the block |
| req_y | input | 2 | Texel row inside the block |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rgb | output | 24 | Decoded colour {R,G,B} |

## Verification
Every result is due one rising edge after the request that caused it. The bench drives a request on a falling edge and reads `rsp_valid` and `rsp_rgb` on the next falling edge, which comes half a period after the capturing edge. In the back-to-back run the bench checks the previous response on the same falling edge where it drives the next request. The hold checks read the outputs on one or more falling edges after `req_valid` has dropped, while the block input keeps changing.

// File: rtl/texblk_pkg.sv
package texblk_pkg;
  localparam int unsigned CH_W   = 8;
  localparam int unsigned N_CH   = 3;
  localparam int unsigned DIM    = 4;
  localparam int unsigned IDX_W  = 2;
  localparam int unsigned SEL_W  = 3;
  localparam int unsigned BLK_W  = 64;
  localparam int unsigned OFS_W  = CH_W + 1;
  localparam int unsigned RGB_W  = N_CH * CH_W;

  // Magnitude of the larger step for one table row.
  function automatic logic [CH_W-1:0] far_step(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd0: far_step = 8'd8;
      3'd1: far_step = 8'd17;
      3'd2: far_step = 8'd29;
      3'd3: far_step = 8'd42;
      3'd4: far_step = 8'd60;
      3'd5: far_step = 8'd80;
      3'd6: far_step = 8'd106;
      default: far_step = 8'd183;
    endcase
  endfunction

  // Magnitude of the smaller step for one table row.
  function automatic logic [CH_W-1:0] near_step(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd0: near_step = 8'd2;
      3'd1: near_step = 8'd5;
      3'd2: near_step = 8'd9;
      3'd3: near_step = 8'd13;
      3'd4: near_step = 8'd18;
      3'd5: near_step = 8'd24;
      3'd6: near_step = 8'd33;
      default: near_step = 8'd47;
    endcase
  endfunction

  // Signed offset: outer indices use the far step, inner ones the near step;
  // the upper index bit sets the sign.
  function automatic logic signed [OFS_W-1:0] lum_offset(input logic [SEL_W-1:0] sel,
                                                         input logic [IDX_W-1:0] idx);
    logic [CH_W-1:0] mag;
    mag = (idx[1] == idx[0]) ? far_step(sel) : near_step(sel);
    lum_offset = idx[1] ? $signed({1'b0, mag}) : -$signed({1'b0, mag});
  endfunction

  // Saturating add of a signed offset to an unsigned channel.
  function automatic logic [CH_W-1:0] sat_add(input logic [CH_W-1:0] base,
                                              input logic signed [OFS_W-1:0] ofs);
    logic signed [CH_W+1:0] sum;
    sum = $signed({2'b00, base}) + (CH_W+2)'(ofs);
    if (sum < 0)
      sat_add = '0;
    else if (sum > $signed({2'b00, {CH_W{1'b1}}}))
      sat_add = '1;
    else
      sat_add = sum[CH_W-1:0];
  endfunction
endpackage

// File: rtl/texblk_unpack.sv
module texblk_unpack
  import texblk_pkg::*;
#(
  parameter int unsigned COORD_W = $clog2(DIM)
) (
  input  logic [BLK_W-1:0]   blk,
  input  logic [COORD_W-1:0] x,
  input  logic [COORD_W-1:0] y,
  output logic [RGB_W-1:0]   base,
  output logic [SEL_W-1:0]   sel,
  output logic [IDX_W-1:0]   idx
);
  localparam int unsigned BASE_LSB = BLK_W - RGB_W;
  localparam int unsigned SEL_LSB  = BASE_LSB - SEL_W;
  localparam int unsigned IDX_BITS = DIM * DIM * IDX_W;

  logic [2*COORD_W-1:0] texel_num;
  logic unused_rsvd_bits;

  assign texel_num = {y, x};
  assign base = blk[BLK_W-1 -: RGB_W];
  assign sel  = blk[SEL_LSB +: SEL_W];
  assign idx  = blk[IDX_W*texel_num +: IDX_W];
  assign unused_rsvd_bits = ^blk[SEL_LSB-1:IDX_BITS];
endmodule

// File: rtl/texblk_lum_lut.sv
module texblk_lum_lut
  import texblk_pkg::*;
(
  input  logic [SEL_W-1:0]        sel,
  input  logic [IDX_W-1:0]        idx,
  output logic signed [OFS_W-1:0] ofs
);
  assign ofs = lum_offset(sel, idx);
endmodule

// File: rtl/texblk_chan_sat.sv
module texblk_chan_sat
  import texblk_pkg::*;
(
  input  logic [CH_W-1:0]         base,
  input  logic signed [OFS_W-1:0] ofs,
  output logic [CH_W-1:0]         res
);
  assign res = sat_add(base, ofs);
endmodule

// File: rtl/texblk_decoder.sv
module texblk_decoder
  import texblk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [63:0]      req_block,
  input  logic [1:0]       req_x,
  input  logic [1:0]       req_y,
  output logic             rsp_valid,
  output logic [23:0]      rsp_rgb
);
  logic [RGB_W-1:0]        unp_base;
  logic [SEL_W-1:0]        unp_sel;
  logic [IDX_W-1:0]        unp_idx;
  logic signed [OFS_W-1:0] lut_ofs;
  logic [RGB_W-1:0]        sat_rgb;

  texblk_unpack u_unpack (
    .blk  (req_block),
    .x    (req_x),
    .y    (req_y),
    .base (unp_base),
    .sel  (unp_sel),
    .idx  (unp_idx)
  );

  texblk_lum_lut u_lut (
    .sel (unp_sel),
    .idx (unp_idx),
    .ofs (lut_ofs)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_chan
    texblk_chan_sat u_sat (
      .base (unp_base[c*CH_W +: CH_W]),
      .ofs  (lut_ofs),
      .res  (sat_rgb[c*CH_W +: CH_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rgb   <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) rsp_rgb <= sat_rgb;
    end
  end
endmodule

// File: rtl/texblk_decoder_chk.sv
module texblk_decoder_chk
  import texblk_pkg::*;
(
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_valid,
  input logic                    rsp_valid,
  input logic [23:0]             rsp_rgb,
  input logic [RGB_W-1:0]        unp_base,
  input logic [IDX_W-1:0]        unp_idx,
  input logic signed [OFS_W-1:0] lut_ofs
);
  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R2
  AST_VALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R2
  AST_HOLD_RGB: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(rsp_rgb)); // R8
  AST_OFS_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ((lut_ofs < 0) == (unp_idx < 2'd2)) && (lut_ofs != 0)); // R4
  AST_DOWN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && lut_ofs < 0) |=>
      (rsp_rgb[23:16] <= $past(unp_base[23:16])) &&
      (rsp_rgb[15:8]  <= $past(unp_base[15:8])) &&
      (rsp_rgb[7:0]   <= $past(unp_base[7:0]))); // R6
  AST_UP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && lut_ofs > 0) |=>
      (rsp_rgb[23:16] >= $past(unp_base[23:16])) &&
      (rsp_rgb[15:8]  >= $past(unp_base[15:8])) &&
      (rsp_rgb[7:0]   >= $past(unp_base[7:0]))); // R6
  AST_GREY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && unp_base[23:16] == unp_base[15:8] && unp_base[15:8] == unp_base[7:0]) |=>
      (rsp_rgb[23:16] == rsp_rgb[15:8]) && (rsp_rgb[15:8] == rsp_rgb[7:0])); // R5
endmodule

bind texblk_decoder texblk_decoder_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .rsp_valid (rsp_valid),
  .rsp_rgb   (rsp_rgb),
  .unp_base  (unp_base),
  .unp_idx   (unp_idx),
  .lut_ofs   (lut_ofs)
);

// File: tb/texblk_decoder_tb.sv
module texblk_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] req_block = '0;
  logic [1:0]  req_x = '0;
  logic [1:0]  req_y = '0;
  logic        rsp_valid;
  logic [23:0] rsp_rgb;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  texblk_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_block(req_block),
    .req_x(req_x), .req_y(req_y), .rsp_valid(rsp_valid), .rsp_rgb(rsp_rgb)
  );

  int far_t[8]  = '{8, 17, 29, 42, 60, 80, 106, 183};
  int near_t[8] = '{2, 5, 9, 13, 18, 24, 33, 47};

  function automatic int clamp8(input int v);
    return (v < 0) ? 0 : ((v > 255) ? 255 : v);
  endfunction

  // Reference model built from R3, R4, R5 and R6.
  function automatic logic [23:0] ref_rgb(input logic [63:0] b, input int x, input int y);
    int sel, idx, ofs, r, g, bl;
    sel = int'(b[39:37]);
    idx = int'((b >> (2 * (4 * y + x))) & 64'd3);
    case (idx)
      0: ofs = -far_t[sel];
      1: ofs = -near_t[sel];
      2: ofs = near_t[sel];
      default: ofs = far_t[sel];
    endcase
    r  = clamp8(int'(b[63:56]) + ofs);
    g  = clamp8(int'(b[55:48]) + ofs);
    bl = clamp8(int'(b[47:40]) + ofs);
    return {r[7:0], g[7:0], bl[7:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  // Drive one request on a falling edge, check the response on the next one.
  task automatic one(input string req, input logic [63:0] b, input int x, input int y,
                     output logic [23:0] got);
    req_valid = 1'b1; req_block = b; req_x = 2'(x); req_y = 2'(y);
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " valid"}, 32'(rsp_valid), 32'd1);
    got = rsp_rgb;
  endtask

  task automatic all_texels(input string req, input logic [63:0] b);
    logic [23:0] got;
    for (int t = 0; t < 16; t++) begin
      one(req, b, t % 4, t / 4, got);
      check(req, 32'(got), 32'(ref_rgb(b, t % 4, t / 4)));
    end
  endtask

  initial begin
    logic [63:0] blk;
    logic [23:0] got, got2, held;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 reset valid", 32'(rsp_valid), 32'd0);
    check("R1 reset rgb", 32'(rsp_rgb), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle valid", 32'(rsp_valid), 32'd0);
    check("R1 idle rgb", 32'(rsp_rgb), 32'd0);

    // R6 low clamp: base 10/20/30, row 7, index 0 (-183)
    one("R6 low", {24'h0A141E, 3'd7, 5'd0, 32'h0}, 1, 2, got);
    check("R6 low clamp", 32'(got), 32'h000000);
    // R6 high clamp: base F0, row 7, index 3 (+183)
    one("R6 high", {24'hF0F0F0, 3'd7, 5'd0, 32'hFFFF_FFFF}, 3, 3, got);
    check("R6 high clamp", 32'(got), 32'hFFFFFF);
    // R6 mixed: row 0, index 2 (+2) -> 02 82 FF
    one("R6 mix", {24'h0080FF, 3'd0, 5'd0, 32'hAAAA_AAAA}, 0, 0, got);
    check("R6 mixed", 32'(got), 32'h0282FF);
    // R3/R4: only texel (3,2) carries index 1 in row 2 (-9); others index 0 (-29)
    blk = {24'h646464, 3'd2, 5'd0, 32'h0040_0000};
    one("R3 pos", blk, 3, 2, got);
    check("R3 texel 3,2", 32'(got), 32'h5B5B5B);
    one("R3 pos", blk, 2, 3, got);
    check("R3 texel 2,3", 32'(got), 32'h474747);
    // R5: grey base stays grey
    one("R5 grey", {24'h777777, 3'd4, 5'd0, 32'h5555_5555}, 1, 1, got);
    check("R5 grey", 32'(got), 32'h656565);

    // R7: reserved bits flipped give identical colours
    for (int n = 0; n < 4; n++) begin
      blk = {$urandom, $urandom};
      for (int t = 0; t < 16; t++) begin
        one("R7", blk & ~64'h1F_0000_0000, t % 4, t / 4, got);
        one("R7", blk | 64'h1F_0000_0000, t % 4, t / 4, got2);
        check("R7 reserved", 32'(got2), 32'(got));
      end
    end

    // R3/R4/R6 random blocks, all texels, including forced extreme bases
    for (int n = 0; n < 40; n++) begin
      blk = {$urandom, $urandom};
      if (n % 8 == 0) blk[63:40] = 24'h00FF08;
      if (n % 8 == 1) blk[63:40] = 24'hFFF802;
      all_texels("R4 random", blk);
    end

    // R8: response held while idle and block input changes
    one("R8 seed", {24'h305070, 3'd3, 5'd0, 32'h1234_5678}, 2, 1, held);
    for (int k = 0; k < 3; k++) begin
      req_block = {$urandom, $urandom};
      req_x = 2'(k);
      @(negedge clk);
      check("R8 hold rgb", 32'(rsp_rgb), 32'(held));
      check("R2 idle valid", 32'(rsp_valid), 32'd0);
    end

    // R9: back-to-back, one request per cycle
    blk = {$urandom, $urandom};
    for (int t = 0; t <= 16; t++) begin
      if (t > 0) begin
        check("R9 b2b valid", 32'(rsp_valid), 32'd1);
        check("R9 b2b rgb", 32'(rsp_rgb), 32'(ref_rgb(blk, (t - 1) % 4, (t - 1) / 4)));
      end
      req_valid = (t < 16);
      req_block = blk; req_x = 2'(t % 4); req_y = 2'(t / 4);
      @(negedge clk);
    end
    check("R2 drop valid", 32'(rsp_valid), 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule